// File: doc/BRIEF.md
# Serial Quad DAC Register Interface

This block is the digital front end of a four-channel, 8-bit DAC that is written over a three-wire serial link. A host lowers a chip-select line and clocks in a 12-bit command word, most significant bit first. The word carries two active-low shutdown requests, a channel address and a data byte. When chip select rises again, the block commits the word. The data byte goes into the input register of the addressed channel, and the per-channel software shutdown flags are updated.

Each channel has two registers in series: an input register and a DAC register. While the load control is held low, the DAC registers follow their input registers. While it is high, they hold their values. This lets a host preload all four channels and then update the four codes together. An asynchronous clear sets every input and DAC register to zero and leaves the serial shift register alone. A clean hardware shutdown flag is ORed into every channel's shutdown output.

The serial clock, chip select, data and load control come from outside the system clock domain. Each passes through a synchronizer with a parameterized number of stages. The serial edges are then found by comparing the synchronized value with its value in the previous cycle.

Top module: `qdac_serial_front`

## Requirements
- R1: After system reset, all four DAC codes are 00h and, with the hardware shutdown input low, all shutdown outputs are low.
- R2: A serial data bit is taken only on a rising serial clock edge while chip select is low. Serial clock edges while chip select is high change nothing, including the bits that a later short frame combines with.
- R3: The command word is 12 bits, sent most significant bit first. Bit 11 is the all-channel shutdown request (active low), bit 10 is the addressed-channel shutdown request (active low), bits 9:8 are the address and bits 7:0 are the data byte. When chip select rises, the byte is written to the input register selected by the address: 0 selects channel A, 1 B, 2 C and 3 D.
- R4: Only the last 12 bits shifted in before chip select rises are used. Earlier bits of a longer frame, such as a 16-bit frame, are dropped.
- R5: A committed word with bit 11 = 0 sets the shutdown flag of all four channels. Its data byte is still written, and register contents are kept during shutdown.
- R6: A committed word with bit 11 = 1 and bit 10 = 0 sets the shutdown flag of the addressed channel only. A word with both bits 0 sets the flags of all four channels.
- R7: A committed word with bits 11 and 10 both 1 clears every software shutdown flag.
- R8: Each channel's shutdown output is the OR of its software flag and the hardware shutdown input.
- R9: While the load control is low, each DAC register follows its input register. While the load control is high, the DAC codes hold.
- R10: The clear input, active low, zeroes all input and DAC registers asynchronously. The serial shift register keeps its content, so a later chip-select pulse with no clocks commits the same word again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Chip select from the host, active low |
| sdata_i | input | 1 | Serial data from the host |
| ld_n_i | input | 1 | Load control, level sensitive, active low |
| clr_n_i | input | 1 | Asynchronous clear of input and DAC registers, active low |
| hw_sd_i | input | 1 | Hardware shutdown flag |
| dac_code_o | output | 32 | DAC codes; channel n is at bits 8n+7:8n |
| sd_o | output | 4 | Per-channel shutdown outputs; bit n is channel n |

## Verification
The bench goes after the following cases:
- A frame of 8 bits sent after serial clocks given with chip select high. A design that shifted on those clocks would decode a different address and data.
- A 16-bit frame whose top nibble is junk. A design that kept the first 12 bits instead of the last 12 would write the wrong channel.
- Shutdown words with each combination of the two request bits. A design that got the precedence or the clear wrong would leave the wrong channels flagged.
- A DAC update attempted while the load control is high. A leaky second register would change the codes early.
- A clear followed by a chip-select pulse with no clocks. A design that also cleared the shift register would recommit zero instead of the last word.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   // Effect of a committed command word on the software shutdown flags
   typedef enum logic [1:0] {
      ACT_WAKE      = 2'd0,
      ACT_SLEEP_ONE = 2'd1,
      ACT_SLEEP_ALL = 2'd2
   } sd_action_e;

   // The all-channel request wins over the addressed-channel request
   function automatic sd_action_e decode_action(input logic all_req_n,
                                                input logic one_req_n);
      if (!all_req_n)      return ACT_SLEEP_ALL;
      else if (!one_req_n) return ACT_SLEEP_ONE;
      else                 return ACT_WAKE;
   endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("qdac_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= {STAGES{RST_VAL}};
      else        stage_q <= {stage_q[STAGES-2:0], d_i};
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx #(
   parameter int FRAME_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               csn_s,
   input  logic               sdat_s,
   output logic [FRAME_W-1:0] word_o,
   output logic               commit_o
);

   logic sclk_q;
   logic csn_q;
   logic shift_en;

   // Rising serial clock while selected shifts one bit in, MSB first
   assign shift_en = sclk_s & ~sclk_q & ~csn_s;
   // Deselect edge commits the last FRAME_W bits
   assign commit_o = csn_s & ~csn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         csn_q  <= 1'b1;
         word_o <= '0;
      end else begin
         sclk_q <= sclk_s;
         csn_q  <= csn_s;
         if (shift_en) word_o <= {word_o[FRAME_W-2:0], sdat_s};
      end
   end

endmodule

// File: rtl/qdac_reg_bank.sv
module qdac_reg_bank
   import qdac_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clr_n,
   input  logic                           commit,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [CODE_W-1:0]              code,
   input  logic                           all_req_n,
   input  logic                           one_req_n,
   input  logic                           load_n,
   output logic [NUM_CH-1:0][CODE_W-1:0]  dac_q,
   output logic [NUM_CH-1:0]              swsd_q
);

   logic       bank_rst_n;
   sd_action_e act;

   assign bank_rst_n = rst_n & clr_n;
   assign act        = decode_action(all_req_n, one_req_n);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic              wr_en;
      logic [CODE_W-1:0] inp_r;
      logic [CODE_W-1:0] dac_r;

      assign wr_en = commit && (addr == ADDR_W'(ch));

      always_ff @(posedge clk or negedge bank_rst_n) begin
         if (!bank_rst_n) begin
            inp_r <= '0;
            dac_r <= '0;
         end else begin
            if (wr_en)   inp_r <= code;
            if (!load_n) dac_r <= inp_r;
         end
      end

      assign dac_q[ch] = dac_r;
   end

   // Software shutdown flags survive the clear input
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swsd_q <= '0;
      end else if (commit) begin
         case (act)
            ACT_WAKE:      swsd_q       <= '0;
            ACT_SLEEP_ALL: swsd_q       <= '1;
            ACT_SLEEP_ONE: swsd_q[addr] <= 1'b1;
            default:       swsd_q       <= swsd_q;
         endcase
      end
   end

endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front #(
   parameter int NUM_CH      = 4,
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HW_SD_SYNC  = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sclk_i,
   input  logic                       csn_i,
   input  logic                       sdata_i,
   input  logic                       ld_n_i,
   input  logic                       clr_n_i,
   input  logic                       hw_sd_i,
   output logic [NUM_CH*CODE_W-1:0]   dac_code_o,
   output logic [NUM_CH-1:0]          sd_o
);

   localparam int ADDR_W  = $clog2(NUM_CH);
   localparam int FRAME_W = 2 + ADDR_W + CODE_W;

   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("qdac_serial_front: NUM_CH must be a power of two, at least 2");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("qdac_serial_front: CODE_W must be positive");
   end

   // Synchronized host signals: {load, select, clock, data}
   logic [3:0] host_s;
   logic       ld_n_s, csn_s, sclk_s, sdat_s;

   qdac_sync #(
      .WIDTH  (4),
      .STAGES (SYNC_STAGES),
      .RST_VAL(4'b1100)
   ) host_sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({ld_n_i, csn_i, sclk_i, sdata_i}),
      .q_o  (host_s)
   );

   assign {ld_n_s, csn_s, sclk_s, sdat_s} = host_s;

   logic hw_sd_w;
   if (HW_SD_SYNC) begin : g_hw_sync
      qdac_sync #(
         .WIDTH  (1),
         .STAGES (SYNC_STAGES),
         .RST_VAL(1'b0)
      ) hw_sync_i (
         .clk  (clk),
         .rst_n(rst_n),
         .d_i  (hw_sd_i),
         .q_o  (hw_sd_w)
      );
   end else begin : g_hw_direct
      assign hw_sd_w = hw_sd_i;
   end

   logic [FRAME_W-1:0] word_w;
   logic               commit_w;

   qdac_frame_rx #(
      .FRAME_W(FRAME_W)
   ) frame_rx_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (sclk_s),
      .csn_s   (csn_s),
      .sdat_s  (sdat_s),
      .word_o  (word_w),
      .commit_o(commit_w)
   );

   logic [NUM_CH-1:0][CODE_W-1:0] dac_w;
   logic [NUM_CH-1:0]             swsd_w;

   qdac_reg_bank #(
      .NUM_CH(NUM_CH),
      .CODE_W(CODE_W),
      .ADDR_W(ADDR_W)
   ) reg_bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_n    (clr_n_i),
      .commit   (commit_w),
      .addr     (word_w[CODE_W +: ADDR_W]),
      .code     (word_w[CODE_W-1:0]),
      .all_req_n(word_w[FRAME_W-1]),
      .one_req_n(word_w[FRAME_W-2]),
      .load_n   (ld_n_s),
      .dac_q    (dac_w),
      .swsd_q   (swsd_w)
   );

   assign dac_code_o = dac_w;
   assign sd_o       = swsd_w | {NUM_CH{hw_sd_w}};

endmodule

// File: rtl/qdac_serial_front_chk.sv
module qdac_serial_front_chk #(
   parameter int NUM_CH     = 4,
   parameter int CODE_W     = 8,
   parameter bit HW_SD_SYNC = 1'b0
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     ld_n_i,
   input logic                     clr_n_i,
   input logic                     hw_sd_i,
   input logic [NUM_CH*CODE_W-1:0] dac_code_o,
   input logic [NUM_CH-1:0]        sd_o,
   input logic                     commit_w
);

   logic [3:0] ld_hist;
   logic       clr_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_hist  <= '0;
         clr_prev <= 1'b0;
      end else begin
         ld_hist  <= {ld_hist[2:0], ld_n_i};
         clr_prev <= clr_n_i;
      end
   end

   // R10
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n_i |-> dac_code_o == '0);

   // R9
   load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&ld_hist) && clr_n_i && clr_prev |-> $stable(dac_code_o));

   // R7
   flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(commit_w) && $stable(hw_sd_i) |-> $stable(sd_o));

   if (!HW_SD_SYNC) begin : g_hw_chk
      // R8
      hw_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hw_sd_i |-> &sd_o);
   end

endmodule

bind qdac_serial_front qdac_serial_front_chk #(
   .NUM_CH    (NUM_CH),
   .CODE_W    (CODE_W),
   .HW_SD_SYNC(HW_SD_SYNC)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ld_n_i    (ld_n_i),
   .clr_n_i   (clr_n_i),
   .hw_sd_i   (hw_sd_i),
   .dac_code_o(dac_code_o),
   .sd_o      (sd_o),
   .commit_w  (commit_w)
);

// File: tb/qdac_serial_front_tb.sv
module qdac_serial_front_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 4;
   localparam int CW         = 8;
   localparam int HALF_BIT   = 4;

   logic clk = 1'b0;
   logic rst_n, sclk, csn, sdata, ld_n, clr_n, hw_sd;
   logic [NCH*CW-1:0] dac_code;
   logic [NCH-1:0]    sd;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [CW-1:0]  exp_inp [NCH];
   logic [CW-1:0]  exp_dac [NCH];
   logic [NCH-1:0] exp_sw;
   logic [11:0]    model_sr;

   always #(CLK_PERIOD/2) clk = ~clk;

   qdac_serial_front dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (sclk),
      .csn_i     (csn),
      .sdata_i   (sdata),
      .ld_n_i    (ld_n),
      .clr_n_i   (clr_n),
      .hw_sd_i   (hw_sd),
      .dac_code_o(dac_code),
      .sd_o      (sd)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Transparent load copies input registers into the DAC model
   task automatic model_settle();
      if (!ld_n)
         for (int c = 0; c < NCH; c++) exp_dac[c] = exp_inp[c];
   endtask

   task automatic model_commit();
      logic [1:0] a;
      a = model_sr[9:8];
      exp_inp[a] = model_sr[7:0];
      if (!model_sr[11])      exp_sw = '1;
      else if (!model_sr[10]) exp_sw[a] = 1'b1;
      else                    exp_sw = '0;
   endtask

   task automatic check_outputs(input string req);
      logic [CW-1:0]  got;
      logic [NCH-1:0] exp_sd;
      for (int c = 0; c < NCH; c++) begin
         got = dac_code[c*CW +: CW];
         checks++;
         if (got !== exp_dac[c]) begin
            errors++;
            $display("FAIL %s: channel %0d code actual %02h expected %02h",
                     req, c, got, exp_dac[c]);
         end
      end
      exp_sd = exp_sw | {NCH{hw_sd}};
      checks++;
      if (sd !== exp_sd) begin
         errors++;
         $display("FAIL %s: shutdown actual %b expected %b", req, sd, exp_sd);
      end
   endtask

   // One frame of n bits (n may be 0) under a single chip-select assertion
   task automatic send_frame(input logic [15:0] bits, input int n);
      csn = 1'b0;
      wait_clk(HALF_BIT);
      for (int i = n - 1; i >= 0; i--) begin
         sdata    = bits[i];
         model_sr = {model_sr[10:0], bits[i]};
         wait_clk(HALF_BIT);
         sclk = 1'b1;
         wait_clk(HALF_BIT);
         sclk = 1'b0;
      end
      wait_clk(HALF_BIT);
      csn = 1'b1;
      wait_clk(10);
      model_commit();
      model_settle();
   endtask

   task automatic set_load(input logic v);
      ld_n = v;
      wait_clk(8);
      model_settle();
   endtask

   task automatic t_reset();
      check_outputs("R1 reset state");
   endtask

   task automatic t_address();
      // R3: one word per channel, load held high so codes hold (R9)
      send_frame(16'h0C11, 12);
      send_frame(16'h0D22, 12);
      send_frame(16'h0E33, 12);
      send_frame(16'h0F44, 12);
      check_outputs("R9 hold while load high");
      set_load(1'b0);
      check_outputs("R3 address decode");
      set_load(1'b1);
      send_frame(16'h0C99, 12);
      check_outputs("R9 new word held back");
      set_load(1'b0);
      check_outputs("R9 transparent update");
   endtask

   task automatic t_long_frame();
      // R4: 16-bit frame with a junk top nibble
      send_frame(16'h5E5A, 16);
      check_outputs("R4 last twelve bits used");
   endtask

   task automatic t_ignore_clocks();
      send_frame(16'h0DAA, 12);
      for (int i = 0; i < 4; i++) begin
         sdata = 1'b1;
         wait_clk(HALF_BIT);
         sclk = 1'b1;
         wait_clk(HALF_BIT);
         sclk = 1'b0;
      end
      // R2: 8 bits combine with the 4 bits left from the previous frame
      send_frame(16'h003C, 8);
      check_outputs("R2 clocks ignored while deselected");
      send_frame(16'h0F00, 12);
   endtask

   task automatic t_all_shutdown();
      send_frame(16'h0177, 12);
      check_outputs("R5 all-channel shutdown keeps data");
      send_frame(16'h0C10, 12);
      check_outputs("R7 wake word clears flags");
   endtask

   task automatic t_one_shutdown();
      send_frame(16'h0955, 12);
      check_outputs("R6 addressed channel only");
      send_frame(16'h0A66, 12);
      check_outputs("R6 second addressed channel");
      send_frame(16'h0388, 12);
      check_outputs("R6 both requests shut all");
      send_frame(16'h0DBB, 12);
      check_outputs("R7 wake after both");
   endtask

   task automatic t_hw_shutdown();
      send_frame(16'h0A01, 12);
      hw_sd = 1'b1;
      wait_clk(3);
      check_outputs("R8 hardware flag ORed");
      hw_sd = 1'b0;
      wait_clk(3);
      check_outputs("R8 hardware flag released");
      send_frame(16'h0C10, 12);
   endtask

   task automatic t_clear();
      send_frame(16'h0EC3, 12);
      clr_n = 1'b0;
      wait_clk(3);
      for (int c = 0; c < NCH; c++) begin
         exp_inp[c] = '0;
         exp_dac[c] = '0;
      end
      check_outputs("R10 clear zeroes codes");
      clr_n = 1'b1;
      wait_clk(6);
      check_outputs("R10 codes stay zero after clear");
      // R10: shift register kept, chip-select pulse recommits it
      send_frame(16'h0000, 0);
      check_outputs("R10 shift register survives clear");
   endtask

   initial begin
      rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; sdata = 1'b0;
      ld_n = 1'b1; clr_n = 1'b1; hw_sd = 1'b0;
      model_sr = '0;
      exp_sw   = '0;
      for (int c = 0; c < NCH; c++) begin
         exp_inp[c] = '0;
         exp_dac[c] = '0;
      end
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
      t_reset();
      t_address();
      t_long_frame();
      t_ignore_clocks();
      t_all_shutdown();
      t_one_shutdown();
      t_hw_shutdown();
      t_clear();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run state actual hung expected complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule